// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is a watchdog built around a counter that advances on every clock from the moment synchronous reset is released. No enable bit exists. The timeout is one of four power-of-two clock counts, picked by a 2-bit select. When the selected count completes, the block raises a sticky warning flag. Software polls this flag. No interrupt request is produced.

The warning opens a fixed grace window of 512 clocks. When the window ends, a sticky reset flag is raised. If the reset-enable input is high at that moment, a one-cycle system reset request is also issued. Software services the watchdog with a restart strobe. The strobe zeroes the counter and cancels any open grace window, but it leaves both flags as they are. Each flag has its own clear strobe.

Top module: `wdt_dly`

## Requirements
- R1: While `srst` is high, and in the cycle after it is released, `irq_flag`, `rst_flag` and `rst_req` are 0 and the counter is zero.
- R2: The counter advances on every clock without any enable. If no restart occurs, `irq_flag` rises after clock edge c0+N, where c0 is the last edge sampled with `srst` high and N is the selected period.
- R3: The period is N = 2^(EXP0 + STEP*tmo_sel). With the defaults, tmo_sel 00 gives 2^17 clocks, 01 gives 2^20, 10 gives 2^23 and 11 gives 2^26.
- R4: If `restart` is sampled high at edge k, `irq_flag` rises after edge k+N.
- R5: `rst_flag` rises exactly GRACE clocks after `irq_flag` was set (default 512). This happens even if `irq_flag` was cleared during the window.
- R6: `rst_req` goes high for exactly one cycle, after the same edge that sets `rst_flag`. It does so only when `rst_en` is 1 at that edge. With `rst_en` 0, only the flag is set.
- R7: `restart` zeroes the counter and cancels an open grace window. It never clears a flag. A restart in the cycle where the count would complete suppresses that expiry.
- R8: Each flag is sticky. It is cleared only by its own strobe (`irq_clr` or `rst_clr`) or by `srst`. When a flag's set and clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, time base of the watchdog |
| srst | input | 1 | Synchronous reset, active high |
| tmo_sel | input | 2 | Timeout select, 00 shortest to 11 longest |
| restart | input | 1 | Service strobe: zero the counter, cancel grace window |
| rst_en | input | 1 | Allows a reset request when the grace window ends |
| irq_clr | input | 1 | Clears the warning flag |
| rst_clr | input | 1 | Clears the reset flag |
| irq_flag | output | 1 | Sticky warning flag, set when the count completes |
| rst_flag | output | 1 | Sticky flag, set when the grace window ends |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two ordering corners are the hardest to reach from the ports. The first is a restart landing on the very edge where the count completes. The second is a clear strobe landing on the edge where its flag is set. The bench reaches both by counting edges from a known restart and driving the strobe on the falling edge just before the computed target edge. A restart issued inside an open grace window is also exercised. The bench then waits past the point where the window would have ended, to confirm that no reset flag or request appears. To keep runs short, the bench shrinks the base exponent and the step, while keeping the 512-clock grace window at its default.

// File: rtl/wdt_dly_pkg.sv
package wdt_dly_pkg;
   localparam int SEL_W   = 2;
   localparam int NUM_TMO = 1 << SEL_W;

   // exponent of the period chosen by select value idx
   function automatic int tmo_exp(input int exp0, input int step, input int idx);
      return exp0 + step * idx;
   endfunction
endpackage

// File: rtl/wdt_dly_count.sv
module wdt_dly_count
   import wdt_dly_pkg::*;
#(
   parameter int EXP0 = 17,
   parameter int STEP = 3
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam int CNT_W = tmo_exp(EXP0, STEP, NUM_TMO - 1);

   logic [CNT_W-1:0]   cnt;
   logic [NUM_TMO-1:0] tap;

   always_ff @(posedge clk) begin
      if (srst || restart) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   // one terminal-count detector per selectable period
   for (genvar i = 0; i < NUM_TMO; i++) begin : g_tap
      localparam int W = tmo_exp(EXP0, STEP, i);
      assign tap[i] = &cnt[W-1:0];
   end

   assign expire = tap[sel] & ~restart & ~srst;
endmodule

// File: rtl/wdt_dly_grace.sv
module wdt_dly_grace #(
   parameter int GRACE = 512
) (
   input  logic clk,
   input  logic srst,
   input  logic restart,
   input  logic start,
   output logic done
);
   localparam int GW = (GRACE > 2) ? $clog2(GRACE) : 1;

   logic          active;
   logic [GW-1:0] gcnt;

   always_ff @(posedge clk) begin
      if (srst || restart) begin
         active <= 1'b0;
         gcnt   <= '0;
      end else if (start) begin
         active <= 1'b1;
         gcnt   <= GW'(GRACE - 1);
      end else if (active) begin
         if (gcnt == '0) active <= 1'b0;
         else            gcnt   <= gcnt - 1'b1;
      end
   end

   assign done = active & (gcnt == '0) & ~restart & ~srst;
endmodule

// File: rtl/wdt_dly_flags.sv
module wdt_dly_flags (
   input  logic clk,
   input  logic srst,
   input  logic set_irq,
   input  logic clr_irq,
   input  logic set_rst,
   input  logic clr_rst,
   input  logic rst_en,
   output logic irq_flag,
   output logic rst_flag,
   output logic rst_req
);
   always_ff @(posedge clk) begin
      if (srst) begin
         irq_flag <= 1'b0;
         rst_flag <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         // a set outranks a clear landing on the same edge
         if (set_irq)      irq_flag <= 1'b1;
         else if (clr_irq) irq_flag <= 1'b0;
         if (set_rst)      rst_flag <= 1'b1;
         else if (clr_rst) rst_flag <= 1'b0;
         rst_req <= set_rst & rst_en;
      end
   end
endmodule

// File: rtl/wdt_dly.sv
module wdt_dly
   import wdt_dly_pkg::*;
#(
   parameter int EXP0  = 17,
   parameter int STEP  = 3,
   parameter int GRACE = 512
) (
   input  logic             clk,
   input  logic             srst,
   input  logic [SEL_W-1:0] tmo_sel,
   input  logic             restart,
   input  logic             rst_en,
   input  logic             irq_clr,
   input  logic             rst_clr,
   output logic             irq_flag,
   output logic             rst_flag,
   output logic             rst_req
);
   // elaboration-time parameter checks
   if (EXP0 < 1 || STEP < 1) begin : g_bad_exp
      $error("wdt_dly: EXP0 and STEP must be positive");
   end
   if (GRACE < 2) begin : g_bad_grace
      $error("wdt_dly: GRACE must be at least 2");
   end
   if ((64'd1 << EXP0) <= 64'(GRACE)) begin : g_bad_ratio
      $error("wdt_dly: shortest period must exceed the grace window");
   end

   logic expire;
   logic grace_done;

   wdt_dly_count #(.EXP0(EXP0), .STEP(STEP)) u_count (
      .clk     (clk),
      .srst    (srst),
      .restart (restart),
      .sel     (tmo_sel),
      .expire  (expire)
   );

   wdt_dly_grace #(.GRACE(GRACE)) u_grace (
      .clk     (clk),
      .srst    (srst),
      .restart (restart),
      .start   (expire),
      .done    (grace_done)
   );

   wdt_dly_flags u_flags (
      .clk      (clk),
      .srst     (srst),
      .set_irq  (expire),
      .clr_irq  (irq_clr),
      .set_rst  (grace_done),
      .clr_rst  (rst_clr),
      .rst_en   (rst_en),
      .irq_flag (irq_flag),
      .rst_flag (rst_flag),
      .rst_req  (rst_req)
   );
endmodule

// File: rtl/wdt_dly_chk.sv
module wdt_dly_chk (
   input logic clk,
   input logic srst,
   input logic restart,
   input logic rst_en,
   input logic irq_clr,
   input logic rst_clr,
   input logic irq_flag,
   input logic rst_flag,
   input logic rst_req
);
   // R6
   req_single_chk: assert property (@(posedge clk) disable iff (srst)
      rst_req |=> !rst_req);
   // R6
   req_enabled_chk: assert property (@(posedge clk) disable iff (srst)
      rst_req |-> $past(rst_en));
   // R6
   req_with_flag_chk: assert property (@(posedge clk) disable iff (srst)
      $rose(rst_req) |-> $rose(rst_flag));
   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (srst)
      ($past(irq_flag) && !$past(irq_clr)) |-> irq_flag);
   // R8
   rst_sticky_chk: assert property (@(posedge clk) disable iff (srst)
      ($past(rst_flag) && !$past(rst_clr)) |-> rst_flag);
   // R7
   irq_restart_chk: assert property (@(posedge clk) disable iff (srst)
      $rose(irq_flag) |-> !$past(restart));
   // R7
   rst_restart_chk: assert property (@(posedge clk) disable iff (srst)
      $rose(rst_flag) |-> !$past(restart));
endmodule

bind wdt_dly wdt_dly_chk u_chk (
   .clk      (clk),
   .srst     (srst),
   .restart  (restart),
   .rst_en   (rst_en),
   .irq_clr  (irq_clr),
   .rst_clr  (rst_clr),
   .irq_flag (irq_flag),
   .rst_flag (rst_flag),
   .rst_req  (rst_req)
);

// File: tb/wdt_dly_tb.sv
`timescale 1ns/1ps
module wdt_dly_tb;
   localparam int EXP0  = 10;
   localparam int STEP  = 1;
   localparam int GRACE = 512;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       srst = 1'b1;
   logic [1:0] tmo_sel = 2'b00;
   logic       restart = 1'b0, rst_en = 1'b0, irq_clr = 1'b0, rst_clr = 1'b0;
   logic       irq_flag, rst_flag, rst_req;

   wdt_dly #(.EXP0(EXP0), .STEP(STEP), .GRACE(GRACE)) u_dut (
      .clk(clk), .srst(srst), .tmo_sel(tmo_sel), .restart(restart),
      .rst_en(rst_en), .irq_clr(irq_clr), .rst_clr(rst_clr),
      .irq_flag(irq_flag), .rst_flag(rst_flag), .rst_req(rst_req)
   );

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   typedef struct {
      int          kind;   // 0 irq flag rise, 1 rst flag rise, 2 reset request
      int unsigned at;
      string       req;
   } ev_t;
   ev_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int unsigned period(input int s);
      return 1 << (EXP0 + STEP * s);
   endfunction

   // driver side of the scoreboard
   task automatic expect_ev(input int kind, input int unsigned at, input string req);
      ev_t e;
      e.kind = kind; e.at = at; e.req = req;
      exp_q.push_back(e);
   endtask

   // monitor side of the scoreboard
   logic irq_q = 1'b0, rst_q = 1'b0;
   task automatic observe(input int kind);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R2", "unexpected event kind", kind, -1);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind, e.req, "event kind", kind, e.kind);
         chk(e.at == cyc, e.req, "event cycle", cyc, e.at);
      end
   endtask

   always @(negedge clk) begin
      if (!srst) begin
         if (irq_flag && !irq_q) observe(0);
         if (rst_flag && !rst_q) observe(1);
         if (rst_req)            observe(2);
      end
      irq_q <= irq_flag;
      rst_q <= rst_flag;
   end

   task automatic wait_until(input int unsigned at);
      while (cyc < at) @(negedge clk);
   endtask

   task automatic restart_now(output int unsigned c0);
      @(negedge clk);
      restart = 1'b1;
      c0 = cyc + 1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic pulse_clr(input bit a, input bit b);
      @(negedge clk);
      irq_clr = a; rst_clr = b;
      @(negedge clk);
      irq_clr = 1'b0; rst_clr = 1'b0;
   endtask

   task automatic drain(input string req);
      chk(exp_q.size() == 0, req, "pending expected events", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual run still going expected finished by %0d cycles", 200000);
      summary();
      $finish;
   end

   initial begin
      int unsigned c0, c1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(irq_flag == 0, "R1", "irq_flag in reset", irq_flag, 0);
      chk(rst_flag == 0, "R1", "rst_flag in reset", rst_flag, 0);
      chk(rst_req  == 0, "R1", "rst_req in reset", rst_req, 0);

      // R2 free running from reset release, no restart, reset disabled
      tmo_sel = 2'b00; rst_en = 1'b0;
      srst = 1'b0; c0 = cyc;
      @(negedge clk);
      chk(irq_flag == 0 && rst_flag == 0 && rst_req == 0, "R1", "outputs after release",
          {irq_flag, rst_flag, rst_req}, 0);
      expect_ev(0, c0 + period(0), "R2");
      expect_ev(1, c0 + period(0) + GRACE, "R5");
      wait_until(c0 + period(0) + GRACE + 4);
      drain("R2");
      chk(rst_req == 0, "R6", "no request with enable low", rst_req, 0);
      restart_now(c0);
      pulse_clr(1, 1);
      chk(irq_flag == 0 && rst_flag == 0, "R8", "both flags cleared",
          {irq_flag, rst_flag}, 0);

      // R4/R5/R6 shortest period, reset enabled, irq cleared inside window
      rst_en = 1'b1;
      restart_now(c0);
      expect_ev(0, c0 + period(0), "R4");
      expect_ev(1, c0 + period(0) + GRACE, "R5");
      expect_ev(2, c0 + period(0) + GRACE, "R6");
      wait_until(c0 + period(0) + 80);
      pulse_clr(1, 0);
      chk(irq_flag == 0, "R8", "irq cleared by its strobe", irq_flag, 0);
      wait_until(c0 + period(0) + GRACE + 4);
      drain("R5");
      chk(rst_flag == 1, "R5", "rst_flag despite irq clear", rst_flag, 1);
      chk(rst_req == 0, "R6", "request lasts one cycle", rst_req, 1'b0);
      pulse_clr(1, 0);
      chk(rst_flag == 1, "R8", "rst_flag kept by irq strobe", rst_flag, 1);
      pulse_clr(0, 1);
      chk(rst_flag == 0, "R8", "rst_flag cleared by own strobe", rst_flag, 0);

      // R3 select 01, reset disabled
      tmo_sel = 2'b01; rst_en = 1'b0;
      restart_now(c0);
      expect_ev(0, c0 + period(1), "R3");
      expect_ev(1, c0 + period(1) + GRACE, "R6");
      wait_until(c0 + period(1) + GRACE + 4);
      drain("R3");
      pulse_clr(1, 1);

      // R3 select 11, reset enabled
      tmo_sel = 2'b11; rst_en = 1'b1;
      restart_now(c0);
      expect_ev(0, c0 + period(3), "R3");
      expect_ev(1, c0 + period(3) + GRACE, "R3");
      expect_ev(2, c0 + period(3) + GRACE, "R6");
      wait_until(c0 + period(3) + GRACE + 4);
      drain("R3");
      pulse_clr(1, 1);

      // R7 restart inside the grace window cancels it
      tmo_sel = 2'b10;
      restart_now(c0);
      expect_ev(0, c0 + period(2), "R3");
      wait_until(c0 + period(2) + 100);
      restart_now(c1);
      wait_until(c1 + GRACE + 200);
      drain("R7");
      chk(rst_flag == 0, "R7", "grace cancelled", rst_flag, 0);
      chk(irq_flag == 1, "R7", "restart keeps irq_flag", irq_flag, 1);
      pulse_clr(1, 0);

      // R7 periodic servicing prevents any expiry
      tmo_sel = 2'b00;
      for (int i = 0; i < 6; i++) begin
         restart_now(c0);
         wait_until(c0 + period(0) - 40);
      end
      chk(irq_flag == 0 && rst_flag == 0, "R7", "serviced watchdog silent",
          {irq_flag, rst_flag}, 0);

      // R8 set beats clear on the same edge
      rst_en = 1'b0;
      restart_now(c0);
      expect_ev(0, c0 + period(0), "R8");
      expect_ev(1, c0 + period(0) + GRACE, "R8");
      wait_until(c0 + period(0) - 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      wait_until(c0 + period(0) + GRACE - 1);
      rst_clr = 1'b1;
      @(negedge clk);
      rst_clr = 1'b0;
      wait_until(c0 + period(0) + GRACE + 4);
      drain("R8");
      chk(irq_flag == 1, "R8", "irq set wins over clear", irq_flag, 1);
      chk(rst_flag == 1, "R8", "rst set wins over clear", rst_flag, 1);
      restart_now(c0);
      pulse_clr(1, 1);

      // R7 restart on the completing edge suppresses that expiry
      restart_now(c0);
      wait_until(c0 + period(0) - 1);
      restart = 1'b1;
      c1 = cyc + 1;
      @(negedge clk);
      restart = 1'b0;
      chk(irq_flag == 0, "R7", "expiry suppressed by restart", irq_flag, 0);
      expect_ev(0, c1 + period(0), "R7");
      expect_ev(1, c1 + period(0) + GRACE, "R7");
      wait_until(c1 + period(0) + GRACE + 4);
      drain("R7");

      summary();
      $finish;
   end
endmodule